// File: doc/BRIEF.md
# Display Enable Border Generator with Character Skew

This block drives the active-high display enable of a character-based raster controller; whenever it is low, the border colour is shown. It keeps two registered border flags and combines them with a split-border term through a NOR. The horizontal flag opens at the start of a raster line and closes once the displayed width has been reached. The vertical flag opens at the first character row and closes at the displayed row count. The split term is the forced-off skew code. It blanks the display without disturbing the counters, which keep running outside this block.

All state advances only in cycles where the character-clock enable is high. A two-bit skew code can delay the combined enable by one or two character clocks, or it can hold the output at border. A two-bit variant input selects among four rule sets. These differ in whether the skew code is honoured, in whether horizontal sync holds the border on across the line start, and in whether the vertical compare is tested on every character or only at the start of a character row.

Top module: `border_timing_gen`

## Requirements
- R1: With an effective skew code of 0, `disp_en` is 1 exactly when both border flags are 0. The flags seen on the output are those updated on the most recent enabled edge.
- R2: On an enabled edge where `hcount` equals `disp_width`, the horizontal flag becomes 1. This set takes priority over any clear.
- R3: On an enabled edge where `hcount` is 0 and the set of R2 does not apply, the horizontal flag becomes 0. R4 gives the one exception.
- R4: With `variant` = 2, the clear of R3 is skipped while `hsync` is 1, so the border stays on. With `variant` 0, 1 or 3, `hsync` has no effect.
- R5: With `variant` 0, 1 or 2, on every enabled edge: if `vcount` equals `disp_rows`, the vertical flag becomes 1. Otherwise, if `vcount` is 0, it becomes 0.
- R6: With `variant` = 3, the vertical set of R5 is tested only at a row start, where `scan_line` and `hcount` are both 0. The clear at `vcount` = 0 is still tested on every enabled edge.
- R7: With `variant` 0 or 3, skew code 3 holds `disp_en` at 0 on every cycle.
- R8: With `variant` 0 or 3, skew code 1 delays the R1 value by one enabled edge, and skew code 2 delays it by two enabled edges.
- R9: With `variant` 1 or 2, `skew_code` is ignored and the output behaves as with code 0.
- R10: When `disp_width` is 0, the set and the clear fall on the same count. The set wins, so the horizontal flag never clears.
- R11: While `rst_n` is low, both flags are 1, both delay stages are 0, and `disp_en` is 0.
- R12: On a cycle where `char_en` is 0, neither flag nor any delay stage changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_en | input | 1 | Character-clock enable |
| hsync | input | 1 | Horizontal sync active |
| variant | input | 2 | Rule-set select, values 0 to 3 |
| skew_code | input | 2 | 0 none, 1 one char, 2 two chars, 3 forced off |
| hcount | input | HCW | Horizontal character count |
| scan_line | input | SLW | Scanline within the character row |
| vcount | input | VCW | Vertical character-row count |
| disp_width | input | HCW | Displayed characters per line |
| disp_rows | input | VCW | Displayed character rows |
| disp_en | output | 1 | Display enable, 0 means border |

## Verification
On every cycle, the in-RTL assertions check the following: each flag's set and clear on its compare; the set priority; the skipped clear under horizontal sync; the row-start gating of the vertical set; the forced-off output; and that a flag holds while the character enable is low. The delay by one or two enabled edges, and the way the variants override the skew code, show only in the bench's reference model. That model runs rasters with gapped enables, widths of zero and rewrites of the row count in mid-row.

// File: rtl/border_pkg.sv
package border_pkg;

   typedef enum logic [1:0] {
      RULES_SKEWED   = 2'd0,
      RULES_PLAIN    = 2'd1,
      RULES_SYNCHOLD = 2'd2,
      RULES_ROWGATED = 2'd3
   } rules_e;

   typedef enum logic [1:0] {
      DLY_ZERO = 2'd0,
      DLY_ONE  = 2'd1,
      DLY_TWO  = 2'd2,
      DLY_OFF  = 2'd3
   } delay_e;

   function automatic logic honours_skew(input logic [1:0] v);
      return (rules_e'(v) == RULES_SKEWED) || (rules_e'(v) == RULES_ROWGATED);
   endfunction

   function automatic logic sync_blocks_open(input logic [1:0] v);
      return rules_e'(v) == RULES_SYNCHOLD;
   endfunction

   function automatic logic rows_at_row_start(input logic [1:0] v);
      return rules_e'(v) == RULES_ROWGATED;
   endfunction

endpackage

// File: rtl/border_hflag.sv
module border_hflag #(
   parameter int HCW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           char_en,
   input  logic [HCW-1:0] hcount,
   input  logic [HCW-1:0] disp_width,
   input  logic           hold_open,
   output logic           flag
);

   logic at_limit;
   logic at_origin;

   assign at_limit  = (hcount == disp_width);
   assign at_origin = (hcount == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b1;
      else if (char_en) begin
         if (at_limit)
            flag <= 1'b1;
         else if (at_origin && !hold_open)
            flag <= 1'b0;
      end
   end

   assert_hset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (char_en && hcount == disp_width) |=> flag);

   assert_hclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (char_en && hcount == '0 && disp_width != '0 && !hold_open) |=> !flag);

   assert_synchold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (char_en && hold_open && flag) |=> flag);

   assert_zero_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (char_en && disp_width == '0 && hcount == '0) |=> flag);

   assert_hhold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !char_en |=> $stable(flag));

endmodule

// File: rtl/border_vflag.sv
module border_vflag #(
   parameter int VCW = 7,
   parameter int HCW = 8,
   parameter int SLW = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           char_en,
   input  logic [VCW-1:0] vcount,
   input  logic [VCW-1:0] disp_rows,
   input  logic [HCW-1:0] hcount,
   input  logic [SLW-1:0] scan_line,
   input  logic           gate_to_row,
   output logic           flag
);

   logic row_start;
   logic set_allowed;
   logic at_limit;
   logic at_origin;

   assign row_start   = (scan_line == '0) && (hcount == '0);
   assign set_allowed = !gate_to_row || row_start;
   assign at_limit    = (vcount == disp_rows);
   assign at_origin   = (vcount == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b1;
      else if (char_en) begin
         if (at_limit && set_allowed)
            flag <= 1'b1;
         else if (at_origin)
            flag <= 1'b0;
      end
   end

   assert_vset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (char_en && !gate_to_row && vcount == disp_rows) |=> flag);

   assert_vclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (char_en && vcount == '0 && disp_rows != '0) |=> !flag);

   assert_rowgate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (char_en && gate_to_row && !(scan_line == '0 && hcount == '0)
       && vcount == disp_rows && vcount != '0) |=> $stable(flag));

   assert_vhold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !char_en |=> $stable(flag));

endmodule

// File: rtl/border_skew.sv
module border_skew #(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       char_en,
   input  logic       raw_en,
   input  logic [1:0] sel,
   input  logic       force_off,
   output logic       de
);
   import border_pkg::*;

   logic [STAGES-1:0] dly;
   logic              picked;

   initial begin
      if (STAGES < 2) $error("border_skew: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dly <= '0;
      else if (char_en)
         dly <= {dly[STAGES-2:0], raw_en};
   end

   always_comb begin
      case (delay_e'(sel))
         DLY_ONE: picked = dly[0];
         DLY_TWO: picked = dly[1];
         default: picked = raw_en;
      endcase
   end

   assign de = picked && !force_off;

   assert_forced_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      force_off |-> !de);

   assert_dly_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !char_en |=> $stable(dly));

endmodule

// File: rtl/border_timing_gen.sv
module border_timing_gen #(
   parameter int HCW    = 8,
   parameter int VCW    = 7,
   parameter int SLW    = 5,
   parameter int STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           char_en,
   input  logic           hsync,
   input  logic [1:0]     variant,
   input  logic [1:0]     skew_code,
   input  logic [HCW-1:0] hcount,
   input  logic [SLW-1:0] scan_line,
   input  logic [VCW-1:0] vcount,
   input  logic [HCW-1:0] disp_width,
   input  logic [VCW-1:0] disp_rows,
   output logic           disp_en
);
   import border_pkg::*;

   initial begin
      if (HCW < 2 || HCW > 16) $error("border_timing_gen: HCW out of range");
      if (VCW < 2 || VCW > 16) $error("border_timing_gen: VCW out of range");
      if (SLW < 1 || SLW > 8)  $error("border_timing_gen: SLW out of range");
   end

   logic h_border;
   logic v_border;
   logic split_border;
   logic skew_on;
   logic hold_open;
   logic raw_en;
   logic [1:0] eff_sel;

   assign skew_on      = honours_skew(variant);
   assign hold_open    = sync_blocks_open(variant) && hsync;
   assign split_border = skew_on && (delay_e'(skew_code) == DLY_OFF);
   assign eff_sel      = skew_on ? skew_code : 2'd0;
   assign raw_en       = !(h_border || v_border);

   border_hflag #(.HCW(HCW)) u_hflag (
      .clk        (clk),
      .rst_n      (rst_n),
      .char_en    (char_en),
      .hcount     (hcount),
      .disp_width (disp_width),
      .hold_open  (hold_open),
      .flag       (h_border)
   );

   border_vflag #(.VCW(VCW), .HCW(HCW), .SLW(SLW)) u_vflag (
      .clk         (clk),
      .rst_n       (rst_n),
      .char_en     (char_en),
      .vcount      (vcount),
      .disp_rows   (disp_rows),
      .hcount      (hcount),
      .scan_line   (scan_line),
      .gate_to_row (rows_at_row_start(variant)),
      .flag        (v_border)
   );

   border_skew #(.STAGES(STAGES)) u_skew (
      .clk       (clk),
      .rst_n     (rst_n),
      .char_en   (char_en),
      .raw_en    (raw_en),
      .sel       (eff_sel),
      .force_off (split_border),
      .de        (disp_en)
   );

   assert_nor_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_en && skew_code == 2'd0) |-> (!h_border && !v_border));

   assert_skew_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!skew_on && (h_border || v_border)) |-> !disp_en);

endmodule

// File: tb/border_timing_gen_bench.sv
`timescale 1ns/1ps
module border_timing_gen_bench;

   localparam int HCW = 8;
   localparam int VCW = 7;
   localparam int SLW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic char_en = 1'b0;
   logic hsync = 1'b0;
   logic [1:0] variant = 2'd0;
   logic [1:0] skew_code = 2'd0;
   logic [HCW-1:0] hcount = '0;
   logic [SLW-1:0] scan_line = '0;
   logic [VCW-1:0] vcount = '0;
   logic [HCW-1:0] disp_width = '0;
   logic [VCW-1:0] disp_rows = '0;
   logic disp_en;

   always #2.5 clk = ~clk;

   border_timing_gen u_border_timing_gen (
      .clk(clk), .rst_n(rst_n), .char_en(char_en), .hsync(hsync),
      .variant(variant), .skew_code(skew_code), .hcount(hcount),
      .scan_line(scan_line), .vcount(vcount), .disp_width(disp_width),
      .disp_rows(disp_rows), .disp_en(disp_en)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // reference model state
   int mh, mv, md1, md2;
   // raster state
   int rh, rs, rv;
   // scenario configuration
   int c_var, c_skew, c_width, c_rows, c_htot, c_maxscan, c_vtot;
   int c_hs_start, c_hs_len, c_gap, c_dyn_rows;

   function automatic int expect_out();
      int code;
      int raw;
      code = (c_var == 0 || c_var == 3) ? c_skew : 0;
      raw  = (mh == 0 && mv == 0) ? 1 : 0;
      if (code == 3) return 0;
      if (code == 1) return md1;
      if (code == 2) return md2;
      return raw;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s cycle %0d: disp_en=%0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   task automatic tick(input string tag);
      int en, hs, rows_now, gate;
      @(negedge clk);
      check(tag, int'(disp_en), expect_out());
      en = (c_gap == 0) ? 1 : ((cyc % c_gap) == 0 ? 1 : 0);
      hs = (((rh - c_hs_start + c_htot + 1) % (c_htot + 1)) < c_hs_len) ? 1 : 0;
      rows_now = c_dyn_rows ? ((cyc / 7) % (c_vtot + 1)) : c_rows;
      char_en    = en[0];
      hsync      = hs[0];
      variant    = c_var[1:0];
      skew_code  = c_skew[1:0];
      hcount     = rh[HCW-1:0];
      scan_line  = rs[SLW-1:0];
      vcount     = rv[VCW-1:0];
      disp_width = c_width[HCW-1:0];
      disp_rows  = rows_now[VCW-1:0];
      @(posedge clk);
      cyc++;
      if (en == 1) begin
         md2 = md1;
         md1 = (mh == 0 && mv == 0) ? 1 : 0;
         if (rh == c_width) mh = 1;
         else if (rh == 0 && !(c_var == 2 && hs == 1)) mh = 0;
         gate = (c_var != 3) || (rs == 0 && rh == 0);
         if (gate && rv == rows_now) mv = 1;
         else if (rv == 0) mv = 0;
         rh++;
         if (rh > c_htot) begin
            rh = 0; rs++;
            if (rs > c_maxscan) begin
               rs = 0; rv++;
               if (rv > c_vtot) rv = 0;
            end
         end
      end
   endtask

   task automatic scenario(input string tag, input int v, input int sk, input int w,
                           input int rows, input int hst, input int hlen,
                           input int gap, input int dyn, input int n);
      c_var = v; c_skew = sk; c_width = w; c_rows = rows;
      c_hs_start = hst; c_hs_len = hlen; c_gap = gap; c_dyn_rows = dyn;
      rh = 0; rs = 0; rv = 0;
      for (int i = 0; i < n; i++) tick(tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      char_en = 1'b1;
      mh = 1; mv = 1; md1 = 0; md2 = 0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R11", int'(disp_en), 0);
      end
      rst_n = 1'b1;
   endtask

   initial begin
      c_htot = 15; c_maxscan = 2; c_vtot = 6;
      c_var = 0; c_skew = 0; c_width = 10; c_rows = 4;
      c_hs_start = 11; c_hs_len = 3; c_gap = 0; c_dyn_rows = 0;
      rh = 0; rs = 0; rv = 0;
      do_reset();
      scenario("R1",  0, 0, 10, 4, 11, 3, 0, 0, 400);
      scenario("R2",  0, 0, 14, 5, 11, 3, 0, 0, 400);
      scenario("R3",  1, 0, 3,  2, 5,  2, 2, 0, 400);
      scenario("R4",  2, 0, 10, 4, 15, 3, 0, 0, 400);
      scenario("R4",  0, 0, 10, 4, 15, 3, 0, 0, 400);
      scenario("R5",  1, 0, 8,  3, 11, 3, 3, 0, 600);
      scenario("R5",  2, 0, 8,  0, 11, 3, 0, 0, 400);
      scenario("R6",  3, 0, 8,  3, 11, 3, 0, 1, 800);
      scenario("R6",  0, 0, 8,  3, 11, 3, 0, 1, 800);
      scenario("R7",  0, 3, 10, 4, 11, 3, 0, 0, 300);
      scenario("R7",  3, 3, 10, 4, 11, 3, 0, 0, 300);
      scenario("R8",  0, 1, 10, 4, 11, 3, 0, 0, 400);
      scenario("R8",  0, 2, 10, 4, 11, 3, 2, 0, 400);
      scenario("R8",  3, 2, 6,  3, 11, 3, 3, 0, 400);
      scenario("R9",  1, 2, 10, 4, 11, 3, 0, 0, 300);
      scenario("R9",  2, 3, 10, 4, 11, 3, 0, 0, 300);
      scenario("R10", 0, 0, 0,  4, 11, 3, 0, 0, 300);
      scenario("R12", 0, 1, 9,  3, 11, 3, 4, 0, 600);
      do_reset();
      scenario("R11", 0, 2, 10, 4, 11, 3, 0, 0, 200);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule